// File: doc/BRIEF.md
# Masked Sticky Error-Status Register

This block collects error conditions for a small control interface and reports them in one read-only status byte. Three per-channel overflow event inputs are latched as sticky flags. A separate clock-ratio error input is reported as a live level. A read-write mask byte selects which sources may reach the status byte at all. A set mask bit enables its source. A cleared mask bit blocks it, and the matching status bit then reads 0.

A simple register bus serves both registers. Read data is combinational in the same cycle as the read strobe. Reading the status address returns the current flags. The sticky overflow flags are then cleared at the clock edge that ends the read cycle. An overflow event that arrives in the same cycle as that read is still latched, so it appears on the next read. The block does not detect overflows or check clock ratios: those conditions arrive as inputs. It has no serial host framing and no interrupt output.

Top module: `errstat_regs`

## Requirements
- R1: After synchronous reset, a read of address 0x19 returns 0x00 and a read of address 0x1A returns 0x00, so every source is blocked.
- R2: A write to address 0x1A stores bits 3:0 of the write data as the mask. A read of 0x1A returns the stored mask in bits 3:0, and bits 7:4 read as 0.
- R3: If an event pulse on `ovf_evt[i]` arrives while mask bit i (i = 0..2) is 1, status bit i reads 1 from the next cycle on. It stays 1 until the status register is read.
- R4: A read of 0x19 returns the current status. The overflow bits are 0 from the following cycle, unless a new event arrives.
- R5: An overflow event in the same cycle as a status read is not returned by that read. It is returned by the next status read.
- R6: While a mask bit is 0, the matching status bit reads 0, and events arriving during that time are not latched.
- R7: A mask bit cleared by a write forces its status bit to 0 from the cycle after the write. Setting the mask bit again does not restore a flag that was latched before.
- R8: Status bit 3 equals `clk_err_lvl` AND mask bit 3 in the same cycle. It is not held after the condition ends, and a read does not clear it.
- R9: A read at any address other than 0x19 and 0x1A returns 0x00 and does not clear any flag. A write to 0x19 changes neither register.
- R10: Status bits 7:4 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for read or write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a status read clears the sticky flags |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle, 0 when not reading |
| ovf_evt | input | 3 | Per-channel overflow event pulses, bit i for channel i+1 |
| clk_err_lvl | input | 1 | Live clock-ratio error condition |

## Verification
A sticky flag that is lost, duplicated or cleared at the wrong edge shows up on the very next status read as a wrong bit. For that reason every event in the bench is followed by one or two reads that pin down the edge where the flag was latched and the edge where it was cleared. A mask register holding the wrong value becomes visible at once, both when the mask is read back and as gating on the next status read. A clock-error bit that is wrongly made sticky shows up on the first read after the condition drops. A side effect on a foreign address is exposed by the status read that follows it.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int REG_W      = 8;
    localparam int ADDR_W     = 8;
    localparam int NUM_OVF    = 3;
    localparam int SRC_W      = NUM_OVF + 1;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h19;
    localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h1A;
    localparam logic [REG_W-1:0]  SRC_KEEP  = REG_W'((1 << SRC_W) - 1);

    // clock error above the channel overflows: bit SRC_W-1 is clk_err
    typedef struct packed {
        logic               clk_err;
        logic [NUM_OVF-1:0] ovf;
    } src_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_STAT = 2'd1,
        ACC_MASK = 2'd2
    } acc_t;

    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a);
        if (a == STAT_ADDR)      return ACC_STAT;
        else if (a == MASK_ADDR) return ACC_MASK;
        else                     return ACC_NONE;
    endfunction

    function automatic logic [REG_W-1:0] widen_src(input src_t s);
        return REG_W'(s);
    endfunction

endpackage

// File: rtl/errstat_mask_reg.sv
module errstat_mask_reg
    import errstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output src_t             mask_o
);
    logic [REG_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (wr_en) mask_q <= wdata & SRC_KEEP;
    end

    assign mask_o = src_t'(mask_q[SRC_W-1:0]);

    logic unused_hi;
    assign unused_hi = ^mask_q[REG_W-1:SRC_W];

    // R2: a write lands in the mask on the next cycle
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mask_o == src_t'($past(wdata[SRC_W-1:0]))));

    // R2: without a write the mask holds
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_o));

endmodule

// File: rtl/errstat_sticky_bank.sv
module errstat_sticky_bank
    import errstat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OVF-1:0] enable,
    input  logic [NUM_OVF-1:0] evt,
    input  logic               clr,
    output logic [NUM_OVF-1:0] flag_o
);
    logic [NUM_OVF-1:0] flag_q;

    for (genvar i = 0; i < NUM_OVF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flag_q[i] <= 1'b0;
            else if (!enable[i]) flag_q[i] <= 1'b0;
            else if (clr)        flag_q[i] <= evt[i];
            else                 flag_q[i] <= flag_q[i] | evt[i];
        end

        // R3: an enabled event is latched
        assert_latch_R3: assert property (@(posedge clk) disable iff (rst)
            (enable[i] && evt[i]) |=> flag_q[i]);

        // R3: a set flag stays set until cleared or masked
        assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && enable[i] && !clr) |=> flag_q[i]);

        // R4: a clear without a fresh event empties the flag
        assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
            (clr && !evt[i]) |=> !flag_q[i]);

        // R6: a masked source cannot be latched
        assert_masked_R6: assert property (@(posedge clk) disable iff (rst)
            !enable[i] |=> !flag_q[i]);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/errstat_read_mux.sv
module errstat_read_mux
    import errstat_pkg::*;
(
    input  logic             rd,
    input  acc_t             acc,
    input  src_t             stat,
    input  src_t             mask,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (acc)
                ACC_STAT: rdata = widen_src(stat);
                ACC_MASK: rdata = widen_src(mask);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/errstat_regs.sv
module errstat_regs
    import errstat_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [REG_W-1:0]          bus_wdata,
    input  logic                      bus_rd,
    output logic [REG_W-1:0]          bus_rdata,
    input  logic [NUM_OVF-1:0]        ovf_evt,
    input  logic                      clk_err_lvl
);
    acc_t               acc;
    src_t               mask;
    src_t               stat;
    logic [NUM_OVF-1:0] flags;
    logic               stat_rd;

    assign acc     = decode_addr(bus_addr);
    assign stat_rd = bus_rd && (acc == ACC_STAT);

    errstat_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr && (acc == ACC_MASK)),
        .wdata  (bus_wdata),
        .mask_o (mask)
    );

    errstat_sticky_bank u_sticky (
        .clk    (clk),
        .rst    (rst),
        .enable (mask.ovf),
        .evt    (ovf_evt),
        .clr    (stat_rd),
        .flag_o (flags)
    );

    assign stat.ovf     = flags & mask.ovf;
    assign stat.clk_err = clk_err_lvl & mask.clk_err;

    errstat_read_mux u_rmux (
        .rd    (bus_rd),
        .acc   (acc),
        .stat  (stat),
        .mask  (mask),
        .rdata (bus_rdata)
    );

    // R9: foreign addresses read zero
    assert_foreign_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr != STAT_ADDR && bus_addr != MASK_ADDR) |-> (bus_rdata == '0));

    // R8: clock error bit tracks the live input under its mask
    assert_clk_live_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_ADDR) |-> (bus_rdata[SRC_W-1] == (clk_err_lvl && mask.clk_err)));

    // R10: upper bits never driven
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1:SRC_W] == '0);

    // R7: a masked channel never reports on a status read
    assert_mask_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_ADDR) |-> ((bus_rdata[NUM_OVF-1:0] & ~mask.ovf) == '0));

endmodule

// File: tb/tb_errstat_regs.sv
module tb_errstat_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] ovf_evt = '0;
    logic       clk_err_lvl = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    errstat_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ovf_evt(ovf_evt), .clk_err_lvl(clk_err_lvl)
    );

    // monitor: compare each read cycle against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: act %02h exp none", bus_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: act %02h exp %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [7:0] wd, input logic [2:0] ev, input logic ce);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        ovf_evt = ev; clk_err_lvl = ce;
        @(posedge clk); #1;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string t,
                          input logic [2:0] ev = 3'b000, input logic ce = 1'b0);
        exp_q.push_back(e);
        tag_q.push_back(t);
        step(1'b1, 1'b0, a, 8'h00, ev, ce);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d, 3'b000, 1'b0);
    endtask

    task automatic idle(input logic [2:0] ev = 3'b000, input logic ce = 1'b0);
        step(1'b0, 1'b0, 8'h00, 8'h00, ev, ce);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        rd_exp(8'h19, 8'h00, "R1 status after reset");
        rd_exp(8'h1A, 8'h00, "R1 mask after reset");

        idle(3'b111, 1'b0);
        wr_reg(8'h1A, 8'hFF);
        rd_exp(8'h1A, 8'h0F, "R2 mask readback upper zero");
        rd_exp(8'h19, 8'h00, "R6 events while masked not latched");

        idle(3'b010);
        rd_exp(8'h19, 8'h02, "R3 channel 2 latched");
        rd_exp(8'h19, 8'h00, "R4 cleared after read");

        idle(3'b001); idle(); idle(); idle();
        rd_exp(8'h19, 8'h01, "R3 flag held over idle cycles");
        rd_exp(8'h19, 8'h00, "R4 second read empty");

        idle(3'b100);
        rd_exp(8'h19, 8'h04, "R5 read returns prior flag", 3'b001);
        rd_exp(8'h19, 8'h01, "R5 same-cycle event kept");

        rd_exp(8'h19, 8'h08, "R8 clock error live", 3'b000, 1'b1);
        rd_exp(8'h19, 8'h08, "R8 not cleared by read", 3'b000, 1'b1);
        rd_exp(8'h19, 8'h00, "R8 not held after condition");

        idle(3'b010);
        rd_exp(8'h20, 8'h00, "R9 foreign address reads zero");
        rd_exp(8'h19, 8'h02, "R9 foreign read no side effect");
        wr_reg(8'h19, 8'hFF);
        rd_exp(8'h1A, 8'h0F, "R9 write to status leaves mask");
        rd_exp(8'h19, 8'h00, "R9 write to status sets nothing");

        idle(3'b100);
        wr_reg(8'h1A, 8'h0B);
        rd_exp(8'h19, 8'h00, "R7 masking forces bit zero");
        wr_reg(8'h1A, 8'h0F);
        rd_exp(8'h19, 8'h00, "R7 unmask does not restore");

        wr_reg(8'h1A, 8'h07);
        rd_exp(8'h19, 8'h00, "R6 masked clock error reads zero", 3'b000, 1'b1);
        wr_reg(8'h1A, 8'h0F);

        idle(3'b111, 1'b1);
        rd_exp(8'h19, 8'h0F, "R10 all sources upper bits zero", 3'b000, 1'b1);
        rd_exp(8'h19, 8'h08, "R10 only clock error remains", 3'b000, 1'b1);

        idle(); idle();
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: act %0d pending exp 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: act timeout exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule